// File: doc/BRIEF.md
# Boundary-Run Test Pattern Engine

This block carries out the self-running test operations of a boundary-scan transceiver while the test controller sits in its idle-run state. It owns the 36 data cells of the boundary register (18 on the A side, 18 on the B side). On every rising edge of the test clock it advances them by one step of the chosen operation: inverting outputs while sampling inputs, generating a pseudo-random pattern, compressing pin values into a signature, or running an 18-bit signature on the receiving side together with an 18-bit pattern or counter on the driving side. Results that drive pins are copied into the output shadow latches on the following falling edge.

The operation is chosen by a 3-bit control register that is scanned in serially and then updated. Which side receives and which side drives comes from the per-byte output-enable cells. When the bytes disagree on the direction of data flow, the engine holds still, which is the bypass behaviour. Seeds reach the cells through a parallel load that stands in for a completed boundary-register scan. An update strobe copies the whole cell array into the shadows.

Top module: `brt_engine`

## Requirements
- R1: After reset the control shift stage and the active operation both hold 3'b010 (signature mode), and all 36 cells and all 36 shadows are 0.
- R2: When ctl_shift is high at a rising edge, the control shift stage moves one place toward bit 0 and ctl_tdi enters bit 2. ctl_tdo always shows bit 0 of the shift stage. When ctl_update is high at a rising edge, the shift stage is copied into the active operation. With neither strobe, both stages hold their values.
- R3: A step happens only when, for every byte i, oe_ab_n[i] differs from oe_ba_n[i], and all bytes have the same oe_ab_n. If oe_ab_n is all 0 (A to B), cells [17:0] receive and cells [35:18] drive. If oe_ba_n is all 0, the sides swap. Under any other pattern the cells and shadows stay unchanged.
- R4: Code 000: on each step the receiving cells take the sampled pin values at their positions and the driving cells invert.
- R5: Code 001: all 36 cells form one shift register. next[0] = c[35] XOR c[10] and next[i] = c[i-1].
- R6: Code 010: next = (the R5 shift of c) XOR pin_in, across all 36 bits. The shadows do not change.
- R7: Code 011: the receiving 18 cells r take next[0] = r[17] XOR r[6], next[i] = r[i-1], XOR the pins on that side. The driving 18 cells take the same 18-bit shift without any pin input.
- R8: Code 111: the receiving side compresses as in R7. The driving side, read as an unsigned number with its lowest cell as bit 0, counts up by 1 and wraps from all ones to 0.
- R9: Codes 100, 101 and 110 leave the cells and shadows unchanged.
- R10: On the falling edge after a step in code 000, 001, 011 or 111, the driving-side shadows take the new cell values and the receiving-side shadows hold. When shadow_upd is high at a falling edge, all shadows take the cell values.
- R11: seed_load at a rising edge loads seed_val into the cells and takes priority over a step. An all-zero seed stays zero under code 001.
- R12: No step happens while run_idle is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_idle | input | 1 | High while the run instruction executes in idle-run |
| ctl_shift | input | 1 | Shift the control register |
| ctl_update | input | 1 | Copy the control shift stage into the active operation |
| ctl_tdi | input | 1 | Serial data into the control register |
| ctl_tdo | output | 1 | Serial data out of the control register |
| oe_ab_n | input | 2 | Per-byte A-to-B output enable, active low |
| oe_ba_n | input | 2 | Per-byte B-to-A output enable, active low |
| pin_in | input | 36 | Sampled pin values, A side in [17:0] |
| seed_load | input | 1 | Load seed_val into the cells |
| seed_val | input | 36 | Seed value |
| shadow_upd | input | 1 | Copy all cells into the shadows at the falling edge |
| cell_q | output | 36 | Cell shift elements |
| shadow_q | output | 36 | Output shadow latches |

## Verification
The bench builds the engine with its defaults: 18 cells per side, 2 bytes, feedback taps at 11 and 7. At those values the shift-out bit of each polynomial and the counter's wrap from all ones are reachable within a few steps from a directed seed. Random runs then mix control scans, direction changes, seeds and shadow updates on every cycle. As a result, a mode switch or a change of direction can fall between a step and the shadow update that follows it.

// File: rtl/brt_pkg.sv
package brt_pkg;
  typedef enum logic [2:0] {
    OP_TOGGLE   = 3'b000,
    OP_PRPG     = 3'b001,
    OP_PSA      = 3'b010,
    OP_PSA_PRPG = 3'b011,
    OP_PSA_CNT  = 3'b111
  } brt_op_e;

  localparam logic [2:0] OP_RESET = 3'b010;
endpackage

// File: rtl/brt_ctl.sv
module brt_ctl
  import brt_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       shift_en,
  input  logic       update_en,
  input  logic       tdi,
  output logic       tdo,
  output logic [2:0] op_q
);
  logic [2:0] sr_q, sr_d, op_d;

  always_comb begin
    sr_d = sr_q;
    op_d = op_q;
    if (shift_en)  sr_d = {tdi, sr_q[2:1]};
    if (update_en) op_d = sr_q;
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= OP_RESET;
      op_q <= OP_RESET;
    end else begin
      sr_q <= sr_d;
      op_q <= op_d;
    end
  end

  assign tdo = sr_q[0];

  p_sr_hold_r2: assert property (@(posedge tck) disable iff (!rst_n)
    !shift_en |=> $stable(sr_q));
  p_op_hold_r2: assert property (@(posedge tck) disable iff (!rst_n)
    !update_en |=> $stable(op_q));
endmodule

// File: rtl/brt_dir.sv
module brt_dir #(
  parameter int NBYTE  = 2,
  parameter int SIDE_W = 18,
  localparam int FULL_W = 2 * SIDE_W
) (
  input  logic [NBYTE-1:0]  oe_ab_n,
  input  logic [NBYTE-1:0]  oe_ba_n,
  output logic              dir_ok,
  output logic              ab_dir,
  output logic [FULL_W-1:0] drive_mask
);
  logic [NBYTE-1:0] byte_one_way;

  for (genvar i = 0; i < NBYTE; i++) begin : g_byte
    assign byte_one_way[i] = oe_ab_n[i] ^ oe_ba_n[i];
  end

  always_comb begin
    ab_dir = (oe_ab_n == '0);
    dir_ok = (&byte_one_way) && ((oe_ab_n == '0) || (oe_ab_n == '1));
    drive_mask = ab_dir ? {{SIDE_W{1'b1}}, {SIDE_W{1'b0}}}
                        : {{SIDE_W{1'b0}}, {SIDE_W{1'b1}}};
  end
endmodule

// File: rtl/brt_step.sv
module brt_step
  import brt_pkg::*;
#(
  parameter int SIDE_W    = 18,
  parameter int LONG_TAP  = 11,
  parameter int SHORT_TAP = 7,
  localparam int FULL_W = 2 * SIDE_W
) (
  input  logic [2:0]        op,
  input  logic              ab_dir,
  input  logic [FULL_W-1:0] cells,
  input  logic [FULL_W-1:0] pins,
  output logic [FULL_W-1:0] nxt,
  output logic              op_ok,
  output logic              drives
);
  logic [SIDE_W-1:0] rx_c, tx_c, rx_p, rx_n, tx_n, rx_sig, tx_gen;
  logic [FULL_W-1:0] long_sh;

  always_comb begin
    rx_c = ab_dir ? cells[SIDE_W-1:0]      : cells[FULL_W-1:SIDE_W];
    tx_c = ab_dir ? cells[FULL_W-1:SIDE_W] : cells[SIDE_W-1:0];
    rx_p = ab_dir ? pins[SIDE_W-1:0]       : pins[FULL_W-1:SIDE_W];
    long_sh = {cells[FULL_W-2:0], cells[FULL_W-1] ^ cells[LONG_TAP-1]};
    rx_sig  = {rx_c[SIDE_W-2:0], rx_c[SIDE_W-1] ^ rx_c[SHORT_TAP-1]} ^ rx_p;
    tx_gen  = {tx_c[SIDE_W-2:0], tx_c[SIDE_W-1] ^ tx_c[SHORT_TAP-1]};
    rx_n = rx_c;
    tx_n = tx_c;
    nxt  = cells;
    op_ok  = 1'b1;
    drives = 1'b1;
    case (op)
      OP_TOGGLE: begin
        rx_n = rx_p;
        tx_n = ~tx_c;
      end
      OP_PSA_PRPG: begin
        rx_n = rx_sig;
        tx_n = tx_gen;
      end
      OP_PSA_CNT: begin
        rx_n = rx_sig;
        tx_n = tx_c + 1'b1;
      end
      OP_PRPG: ;
      OP_PSA: drives = 1'b0;
      default: begin
        op_ok  = 1'b0;
        drives = 1'b0;
      end
    endcase
    if (op == OP_PRPG)     nxt = long_sh;
    else if (op == OP_PSA) nxt = long_sh ^ pins;
    else                   nxt = ab_dir ? {tx_n, rx_n} : {rx_n, tx_n};
  end
endmodule

// File: rtl/brt_engine.sv
module brt_engine
  import brt_pkg::*;
#(
  parameter int SIDE_W    = 18,
  parameter int NBYTE     = 2,
  parameter int LONG_TAP  = 11,
  parameter int SHORT_TAP = 7
) (
  input  logic                  tck,
  input  logic                  rst_n,
  input  logic                  run_idle,
  input  logic                  ctl_shift,
  input  logic                  ctl_update,
  input  logic                  ctl_tdi,
  output logic                  ctl_tdo,
  input  logic [NBYTE-1:0]      oe_ab_n,
  input  logic [NBYTE-1:0]      oe_ba_n,
  input  logic [2*SIDE_W-1:0]   pin_in,
  input  logic                  seed_load,
  input  logic [2*SIDE_W-1:0]   seed_val,
  input  logic                  shadow_upd,
  output logic [2*SIDE_W-1:0]   cell_q,
  output logic [2*SIDE_W-1:0]   shadow_q
);
  localparam int FULL_W = 2 * SIDE_W;

  logic [2:0]        op_q;
  logic              dir_ok, ab_dir, op_ok, drives, step_en;
  logic [FULL_W-1:0] drive_mask, step_nxt;
  logic [FULL_W-1:0] cell_d, pend_q, pend_d, shadow_d;

  brt_ctl u_ctl (
    .tck(tck), .rst_n(rst_n), .shift_en(ctl_shift), .update_en(ctl_update),
    .tdi(ctl_tdi), .tdo(ctl_tdo), .op_q(op_q)
  );

  brt_dir #(.NBYTE(NBYTE), .SIDE_W(SIDE_W)) u_dir (
    .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n), .dir_ok(dir_ok),
    .ab_dir(ab_dir), .drive_mask(drive_mask)
  );

  brt_step #(.SIDE_W(SIDE_W), .LONG_TAP(LONG_TAP), .SHORT_TAP(SHORT_TAP)) u_step (
    .op(op_q), .ab_dir(ab_dir), .cells(cell_q), .pins(pin_in),
    .nxt(step_nxt), .op_ok(op_ok), .drives(drives)
  );

  assign step_en = run_idle && dir_ok && op_ok && !seed_load;

  always_comb begin
    cell_d = cell_q;
    pend_d = '0;
    if (seed_load) begin
      cell_d = seed_val;
    end else if (step_en) begin
      cell_d = step_nxt;
      if (drives) pend_d = drive_mask;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      cell_q <= '0;
      pend_q <= '0;
    end else begin
      cell_q <= cell_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    if (shadow_upd) shadow_d = cell_q;
    else            shadow_d = (shadow_q & ~pend_q) | (cell_q & pend_q);
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= shadow_d;
  end

  p_idle_hold_r12: assert property (@(posedge tck) disable iff (!rst_n)
    (!run_idle && !seed_load) |=> $stable(cell_q));
  p_bypass_hold_r3: assert property (@(posedge tck) disable iff (!rst_n)
    (!dir_ok && !seed_load) |=> $stable(cell_q));
  p_zero_seed_r11: assert property (@(posedge tck) disable iff (!rst_n)
    (op_q == OP_PRPG && cell_q == '0 && !seed_load) |=> (cell_q == '0));
  p_count_up_r8: assert property (@(posedge tck) disable iff (!rst_n)
    (run_idle && dir_ok && ab_dir && !seed_load && op_q == OP_PSA_CNT)
    |=> (cell_q[FULL_W-1:SIDE_W] == $past(cell_q[FULL_W-1:SIDE_W]) + 1'b1));
  p_noop_hold_r9: assert property (@(posedge tck) disable iff (!rst_n)
    (!op_ok && !seed_load) |=> $stable(cell_q));
endmodule

// File: tb/brt_engine_bench.sv
module brt_engine_bench;
  localparam int SW = 18;
  localparam int FW = 36;

  logic tck = 1'b0;
  always #10 tck = ~tck;

  logic rst_n, run_idle, ctl_shift, ctl_update, ctl_tdi, ctl_tdo;
  logic seed_load, shadow_upd;
  logic [1:0] oe_ab_n, oe_ba_n;
  logic [FW-1:0] pin_in, seed_val, cell_q, shadow_q;

  brt_engine u_brt_engine (
    .tck(tck), .rst_n(rst_n), .run_idle(run_idle), .ctl_shift(ctl_shift),
    .ctl_update(ctl_update), .ctl_tdi(ctl_tdi), .ctl_tdo(ctl_tdo),
    .oe_ab_n(oe_ab_n), .oe_ba_n(oe_ba_n), .pin_in(pin_in),
    .seed_load(seed_load), .seed_val(seed_val), .shadow_upd(shadow_upd),
    .cell_q(cell_q), .shadow_q(shadow_q)
  );

  int checks = 0;
  int errors = 0;
  logic [2:0]    m_sr, m_op;
  logic [FW-1:0] m_cells, m_sh, m_pend;

  function automatic logic [SW-1:0] sh18(logic [SW-1:0] x);
    return {x[SW-2:0], x[17] ^ x[6]};
  endfunction

  function automatic logic [FW-1:0] model_step(logic [2:0] op, logic [FW-1:0] c,
                                               logic [FW-1:0] p, logic ab);
    logic [SW-1:0] rx, tx, rp, rn, tn;
    rx = ab ? c[SW-1:0] : c[FW-1:SW];
    tx = ab ? c[FW-1:SW] : c[SW-1:0];
    rp = ab ? p[SW-1:0] : p[FW-1:SW];
    rn = rx;
    tn = tx;
    case (op)
      3'b001: return {c[FW-2:0], c[35] ^ c[10]};
      3'b010: return {c[FW-2:0], c[35] ^ c[10]} ^ p;
      3'b000: begin rn = rp; tn = ~tx; end
      3'b011: begin rn = sh18(rx) ^ rp; tn = sh18(tx); end
      3'b111: begin rn = sh18(rx) ^ rp; tn = tx + 18'd1; end
      default: return c;
    endcase
    return ab ? {tn, rn} : {rn, tn};
  endfunction

  task automatic chk(string tag, string what, logic [FW-1:0] act, logic [FW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag);
    logic [2:0] sr_n, op_n;
    logic valid, ab;
    @(posedge tck);
    sr_n = ctl_shift ? {ctl_tdi, m_sr[2:1]} : m_sr;
    op_n = ctl_update ? m_sr : m_op;
    valid = (oe_ab_n[0] != oe_ba_n[0]) && (oe_ab_n[1] != oe_ba_n[1]) &&
            (oe_ab_n[0] == oe_ab_n[1]);
    ab = (oe_ab_n == 2'b00);
    m_pend = '0;
    if (seed_load) m_cells = seed_val;
    else if (run_idle && valid && (m_op inside {3'b000, 3'b001, 3'b010, 3'b011, 3'b111})) begin
      m_cells = model_step(m_op, m_cells, pin_in, ab);
      if (m_op != 3'b010)
        m_pend = ab ? {{SW{1'b1}}, {SW{1'b0}}} : {{SW{1'b0}}, {SW{1'b1}}};
    end
    m_sr = sr_n;
    m_op = op_n;
    #5;
    chk(tag, "cells", cell_q, m_cells);
    chk(tag, "tdo", {35'd0, ctl_tdo}, {35'd0, m_sr[0]});
    @(negedge tck);
    if (shadow_upd) m_sh = m_cells;
    else m_sh = (m_sh & ~m_pend) | (m_cells & m_pend);
    #2;
    chk(tag, "shadow", shadow_q, m_sh);
  endtask

  task automatic quiet();
    run_idle = 0; ctl_shift = 0; ctl_update = 0; seed_load = 0; shadow_upd = 0;
  endtask

  task automatic set_op(logic [2:0] op);
    quiet();
    for (int i = 0; i < 3; i++) begin
      ctl_shift = 1; ctl_tdi = op[i];
      cyc("R2");
    end
    ctl_shift = 0; ctl_update = 1;
    cyc("R2");
    ctl_update = 0;
  endtask

  task automatic seed(logic [FW-1:0] v);
    quiet();
    seed_load = 1; seed_val = v;
    cyc("R11");
    seed_load = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; quiet(); ctl_tdi = 0;
    oe_ab_n = 2'b00; oe_ba_n = 2'b11; pin_in = '0; seed_val = '0;
    m_sr = 3'b010; m_op = 3'b010; m_cells = '0; m_sh = '0; m_pend = '0;
    repeat (3) @(posedge tck);
    #5 rst_n = 1;
    #1;
    chk("R1", "cells", cell_q, '0);
    chk("R1", "shadow", shadow_q, '0);
    chk("R1", "tdo", {35'd0, ctl_tdo}, 36'd0);

    // R1 / R6: reset operation compresses, shadows stay
    seed(36'h9_1234_5678);
    shadow_upd = 1; cyc("R10");
    shadow_upd = 0;
    run_idle = 1;
    for (int i = 0; i < 4; i++) begin
      pin_in = 36'({$urandom(), $urandom()});
      cyc("R6");
    end
    quiet();
    // R2: scan out the reset value
    ctl_shift = 1; ctl_tdi = 1; cyc("R2"); cyc("R2"); cyc("R2");
    ctl_shift = 0; cyc("R2");

    // R4 toggle both directions
    set_op(3'b000);
    seed(36'h5_A5A5_A5A5);
    run_idle = 1;
    for (int i = 0; i < 3; i++) begin
      pin_in = 36'({$urandom(), $urandom()});
      cyc("R4");
    end
    oe_ab_n = 2'b11; oe_ba_n = 2'b00;
    for (int i = 0; i < 3; i++) begin
      pin_in = 36'({$urandom(), $urandom()});
      cyc("R4");
    end

    // R5 full pattern, then R11 zero seed
    set_op(3'b001);
    seed(36'h8_0000_0401);
    run_idle = 1;
    repeat (5) cyc("R5");
    seed('0);
    run_idle = 1;
    repeat (3) cyc("R11");
    chk("R11", "zero seed", cell_q, '0);

    // R7 split signature plus pattern
    set_op(3'b011);
    seed(36'h3_FFFF_0001);
    run_idle = 1;
    for (int i = 0; i < 4; i++) begin
      pin_in = 36'({$urandom(), $urandom()});
      cyc("R7");
    end

    // R8 counter wrap, A to B
    set_op(3'b111);
    oe_ab_n = 2'b00; oe_ba_n = 2'b11;
    seed({18'h3FFFF, 18'h0});
    run_idle = 1; pin_in = '0;
    cyc("R8");
    chk("R8", "wrap", cell_q, '0);
    repeat (2) cyc("R8");

    // R3 invalid directions
    oe_ab_n = 2'b00; oe_ba_n = 2'b00; cyc("R3");
    oe_ab_n = 2'b01; oe_ba_n = 2'b10; cyc("R3");
    oe_ab_n = 2'b00; oe_ba_n = 2'b11;

    // R12 idle low
    run_idle = 0; cyc("R12");

    // R11 seed beats a step
    run_idle = 1; seed_load = 1; seed_val = 36'h0_00F0_000F; cyc("R11");
    seed_load = 0;

    // R9 unused codes
    for (int k = 4; k < 7; k++) begin
      set_op(3'(k));
      run_idle = 1; pin_in = 36'({$urandom(), $urandom()});
      cyc("R9"); cyc("R9");
    end

    // random mix
    for (int i = 0; i < 800; i++) begin
      run_idle   = ($urandom_range(9) < 8);
      ctl_shift  = ($urandom_range(3) == 0);
      ctl_tdi    = 1'($urandom());
      ctl_update = ($urandom_range(7) == 0);
      seed_load  = ($urandom_range(19) == 0);
      shadow_upd = ($urandom_range(19) == 0);
      seed_val   = 36'({$urandom(), $urandom()});
      pin_in     = 36'({$urandom(), $urandom()});
      if ($urandom_range(9) < 7) begin
        oe_ab_n = {2{1'($urandom())}};
        oe_ba_n = ~oe_ab_n;
      end else begin
        oe_ab_n = 2'($urandom()); oe_ba_n = 2'($urandom());
      end
      cyc("R10");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule